// File: doc/BRIEF.md
# Parallel EPROM Word Read Controller

This block is a synchronous bus master that fetches 16-bit words from a bank of asynchronous parallel EPROMs. A request carries a 20-bit word address. The upper two bits pick one device. The lower 18 bits drive the shared address bus.

The controller uses two-line control. Each device has its own decoded chip-enable strobe, and a single output-enable line is shared by every device. Only the selected device leaves standby. A device drives the data bus only when both of its strobes are low.

The wait states come from a speed-grade input. For each grade, the address/chip-enable access time and the shorter output-enable access time are each turned into a clock count by ceiling division with the clock period. Output enable is delayed so that both counts expire on the same edge. The bus is sampled on that edge and returned with a one-cycle valid pulse. After the strobes are released, a 50 ns bus-float guard must pass before a new access can begin. A request presented during that guard waits for the ready signal and is not lost.

Top module: `prom_reader`

## Requirements
- R1: While reset is held and after it is released, every chip enable and the output enable are high (inactive), the response valid is low and request ready is high.
- R2: During an access exactly one chip enable is low. Its index equals request address bits [19:18]. The address bus carries request bits [17:0].
- R3: Output enable is low only while some chip enable is low.
- R4: The response valid is a single-cycle pulse. It rises ceil(tAddr / period) cycles after the edge that accepted the request, and its data is the bus value sampled on that edge.
- R5: At the sampling edge, output enable has been low for at least ceil(tOe / period) cycles, so the device has had its full output-enable access time.
- R6: Speed grade 0 uses tAddr 120 ns and tOe 60 ns. Grade 1 uses 150 ns and 80 ns. Grades 2 and 3 use 200 ns and 100 ns. The grade is taken at acceptance.
- R7: From the cycle of the response pulse, request ready stays low and all chip enables stay high for exactly ceil(50 ns / period) cycles.
- R8: A request held valid while ready is low is accepted once ready returns. No request is dropped, and responses come back in request order.
- R9: The address bus does not change while any chip enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| grade | input | 2 | Speed grade selecting the access times |
| reqValid | input | 1 | Read request present |
| reqAddr | input | 20 | Bank select [19:18] and word address [17:0] |
| reqReady | output | 1 | High when a request is accepted on this edge |
| romAddr | output | 18 | Shared address bus to the devices |
| romCeN | output | 4 | Per-device chip enables, active low |
| romOeN | output | 1 | Shared output enable, active low |
| romData | input | 16 | Data bus from the devices |
| rspValid | output | 1 | One-cycle response strobe |
| rspData | output | 16 | Captured word |

## Verification
A counter or state fault in the control shows at the ports within one access. If the sampling edge is early, the device model returns a poison word instead of the expected pattern. The response latency also moves away from the grade's cycle count. A bad bank decode or an address that changes mid-access corrupts the word on that same response. A float-guard fault changes how long ready stays low after the response pulse, and that count is compared against the guard length on every transaction.

// File: rtl/prom_reader_pkg.sv
package prom_reader_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_FLOAT} rdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic ceOn;
    logic oeOn;
    logic capture;
  } dpStrobe_t;

  localparam int T_FLOAT_NS = 50;

  function automatic int ceilDiv(input int ns, input int period);
    return (ns + period - 1) / period;
  endfunction

endpackage

// File: rtl/prom_reader_ctrl.sv
module prom_reader_ctrl
  import prom_reader_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int CNT_W = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] grade,
  input  logic       reqValid,
  output logic       reqReady,
  output dpStrobe_t  strobe
);

  localparam int A_G0 = ceilDiv(120, CLK_PERIOD_NS);
  localparam int A_G1 = ceilDiv(150, CLK_PERIOD_NS);
  localparam int A_G2 = ceilDiv(200, CLK_PERIOD_NS);
  localparam int O_G0 = ceilDiv(60, CLK_PERIOD_NS);
  localparam int O_G1 = ceilDiv(80, CLK_PERIOD_NS);
  localparam int O_G2 = ceilDiv(100, CLK_PERIOD_NS);
  localparam int FLT_CYC = ceilDiv(T_FLOAT_NS, CLK_PERIOD_NS);

  rdState_t state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] addrCyc;
  logic [CNT_W-1:0] leadCyc;
  logic [CNT_W-1:0] aNext;
  logic [CNT_W-1:0] oNext;
  logic accessDone;
  logic floatDone;

  always_comb begin
    case (grade)
      2'd0:    begin aNext = CNT_W'(A_G0); oNext = CNT_W'(O_G0); end
      2'd1:    begin aNext = CNT_W'(A_G1); oNext = CNT_W'(O_G1); end
      default: begin aNext = CNT_W'(A_G2); oNext = CNT_W'(O_G2); end
    endcase
  end

  assign accessDone = (state == ST_ACCESS) && (cnt == addrCyc - CNT_W'(1));
  assign floatDone  = (state == ST_FLOAT) && (cnt == CNT_W'(FLT_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      addrCyc <= '0;
      leadCyc <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state   <= ST_ACCESS;
            cnt     <= '0;
            addrCyc <= aNext;
            leadCyc <= aNext - oNext;
          end
        end
        ST_ACCESS: begin
          if (accessDone) begin
            state <= ST_FLOAT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: begin
          if (floatDone) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      endcase
    end
  end

  assign reqReady       = (state == ST_IDLE);
  assign strobe.load    = (state == ST_IDLE) && reqValid;
  assign strobe.ceOn    = (state == ST_ACCESS);
  assign strobe.oeOn    = (state == ST_ACCESS) && (cnt >= leadCyc);
  assign strobe.capture = accessDone;

endmodule

// File: rtl/prom_reader_dp.sv
module prom_reader_dp
  import prom_reader_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BANK_W = 2,
  parameter int DATA_W = 16,
  localparam int NUM_DEV = 1 << BANK_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobe_t                strobe,
  input  logic [BANK_W+ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]        romData,
  output logic [ADDR_W-1:0]        romAddr,
  output logic [NUM_DEV-1:0]       romCeN,
  output logic                     romOeN,
  output logic                     rspValid,
  output logic [DATA_W-1:0]        rspData
);

  logic [BANK_W-1:0] bankQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      romAddr  <= '0;
      bankQ    <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      if (strobe.load) begin
        romAddr <= reqAddr[ADDR_W-1:0];
        bankQ   <= reqAddr[BANK_W+ADDR_W-1:ADDR_W];
      end
      rspValid <= strobe.capture;
      if (strobe.capture) rspData <= romData;
    end
  end

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_ce
    assign romCeN[i] = !(strobe.ceOn && (bankQ == BANK_W'(i)));
  end

  assign romOeN = !strobe.oeOn;

endmodule

// File: rtl/prom_reader.sv
module prom_reader
  import prom_reader_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int ADDR_W = 18,
  parameter int BANK_W = 2,
  parameter int DATA_W = 16,
  localparam int NUM_DEV = 1 << BANK_W,
  localparam int MAX_CYC = ceilDiv(200, CLK_PERIOD_NS),
  localparam int CNT_W = $clog2(MAX_CYC + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               grade,
  input  logic                     reqValid,
  input  logic [BANK_W+ADDR_W-1:0] reqAddr,
  output logic                     reqReady,
  output logic [ADDR_W-1:0]        romAddr,
  output logic [NUM_DEV-1:0]       romCeN,
  output logic                     romOeN,
  input  logic [DATA_W-1:0]        romData,
  output logic                     rspValid,
  output logic [DATA_W-1:0]        rspData
);

  dpStrobe_t strobe;

  prom_reader_ctrl #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .grade(grade),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .strobe(strobe)
  );

  prom_reader_dp #(
    .ADDR_W(ADDR_W),
    .BANK_W(BANK_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .reqAddr(reqAddr),
    .romData(romData),
    .romAddr(romAddr),
    .romCeN(romCeN),
    .romOeN(romOeN),
    .rspValid(rspValid),
    .rspData(rspData)
  );

endmodule

// File: rtl/prom_reader_chk.sv
module prom_reader_chk #(
  parameter int ADDR_W = 18,
  parameter int NUM_DEV = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic [ADDR_W-1:0] romAddr,
  input logic [NUM_DEV-1:0] romCeN,
  input logic              romOeN,
  input logic              rspValid
);

  // R2
  one_device_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~romCeN));

  // R3
  oe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    !romOeN |-> (romCeN != '1));

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R7
  float_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (!reqReady && (romCeN == '1) && romOeN));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (romCeN != '1) |=> ((romCeN == '1) || $stable(romAddr)));

endmodule

bind prom_reader prom_reader_chk #(
  .ADDR_W(ADDR_W),
  .NUM_DEV(NUM_DEV)
) u_chk (
  .clk(clk),
  .rstN(rstN),
  .reqReady(reqReady),
  .romAddr(romAddr),
  .romCeN(romCeN),
  .romOeN(romOeN),
  .rspValid(rspValid)
);

// File: tb/prom_reader_tb.sv
`timescale 1ns/1ps
module prom_reader_tb;

  localparam int CLK_PERIOD = 10;
  localparam int FLT = (50 + CLK_PERIOD - 1) / CLK_PERIOD;

  typedef struct {
    logic [15:0] data;
    int          lat;
    int          acc;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  grade = 2'd0;
  logic        reqValid = 1'b0;
  logic [19:0] reqAddr = '0;
  logic        reqReady;
  logic [17:0] romAddr;
  logic [3:0]  romCeN;
  logic        romOeN;
  logic [15:0] romData;
  logic        rspValid;
  logic [15:0] rspData;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int issued = 0;
  int received = 0;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  prom_reader #(.CLK_PERIOD_NS(CLK_PERIOD)) u_dut (
    .clk(clk), .rstN(rstN), .grade(grade), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqReady(reqReady), .romAddr(romAddr),
    .romCeN(romCeN), .romOeN(romOeN), .romData(romData),
    .rspValid(rspValid), .rspData(rspData)
  );

  function automatic int cdiv(input int ns);
    return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
  endfunction

  function automatic int aNs(input logic [1:0] g);
    return (g == 2'd0) ? 120 : (g == 2'd1) ? 150 : 200;
  endfunction

  function automatic int oNs(input logic [1:0] g);
    return (g == 2'd0) ? 60 : (g == 2'd1) ? 80 : 100;
  endfunction

  function automatic logic [15:0] pat(input logic [1:0] b, input logic [17:0] a);
    return a[15:0] ^ {a[17:16], 14'h0} ^ ({14'h0, b} * 16'h1111) ^ 16'h5A3C;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // device model: a word appears only after the full access times
  int ceCnt = 0;
  int oeCnt = 0;
  int mA = 1;
  int mO = 1;
  logic [1:0]  mBank = '0;
  logic [17:0] mAddr = '0;

  always @(posedge clk) begin
    ceCnt <= (romCeN != 4'hF) ? ceCnt + 1 : 0;
    oeCnt <= (!romOeN) ? oeCnt + 1 : 0;
    if (reqValid && reqReady) begin
      mA    <= cdiv(aNs(grade));
      mO    <= cdiv(oNs(grade));
      mBank <= reqAddr[19:18];
      mAddr <= reqAddr[17:0];
    end
    cyc <= cyc + 1;
  end

  always_comb begin
    romData = 16'hDEAD;
    if (!romOeN && (ceCnt + 1 >= mA) && (oeCnt + 1 >= mO)) begin
      for (int i = 0; i < 4; i++)
        if (romCeN == ~(4'b0001 << i)) romData = pat(2'(i), romAddr);
    end
  end

  task automatic issue(input logic [1:0] b, input logic [17:0] a, input logic [1:0] g);
    expItem_t it;
    @(negedge clk);
    reqAddr  = {b, a};
    grade    = g;
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    it.data = pat(b, a);
    it.lat  = cdiv(aNs(g));
    it.acc  = cyc;
    expQ.push_back(it);
    issued++;
  endtask

  // monitor / scoreboard
  bit   inFloat = 0;
  int   fltCnt = 0;
  logic prevRsp = 0;
  logic prevCe = 0;
  logic [17:0] prevAddr = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (!romOeN && romCeN == 4'hF) check(0, "R3 oe without ce", romCeN, 4'hF);
      if (romCeN != 4'hF) begin
        if (romCeN != ~(4'b0001 << mBank)) check(0, "R2 ce decode", romCeN, ~(4'b0001 << mBank));
        if (romAddr != mAddr) check(0, "R2 address bus", romAddr, mAddr);
        if (prevCe && romAddr != prevAddr) check(0, "R9 address moved", romAddr, prevAddr);
      end
      if (rspValid && prevRsp) check(0, "R4 pulse width", 2, 1);
      if (rspValid) begin
        expItem_t it;
        received++;
        if (expQ.size() == 0) check(0, "R8 unexpected response", received, issued);
        else begin
          it = expQ.pop_front();
          // R4 R5 R6: data only valid if both access times were honoured
          check(rspData == it.data, "R5 data", rspData, it.data);
          // R4 R6
          check(cyc - it.acc == it.lat, "R4 latency", cyc - it.acc, it.lat);
        end
        check(!reqReady, "R7 ready at response", reqReady, 0);
        inFloat = 1;
        fltCnt = 1;
      end else if (inFloat) begin
        if (!reqReady) begin
          fltCnt++;
          if (romCeN != 4'hF) check(0, "R7 ce in guard", romCeN, 4'hF);
        end else begin
          check(fltCnt == FLT, "R7 float length", fltCnt, FLT);
          inFloat = 0;
        end
      end
      prevCe   = (romCeN != 4'hF);
      prevAddr = romAddr;
    end
    prevRsp = rspValid;
  end

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(romCeN == 4'hF, "R1 ce in reset", romCeN, 4'hF);
    check(romOeN == 1'b1, "R1 oe in reset", romOeN, 1);
    check(!rspValid, "R1 valid in reset", rspValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady, "R1 ready after reset", reqReady, 1);
    check(romCeN == 4'hF && romOeN, "R1 idle strobes", {romCeN, romOeN}, 5'h1F);

    // isolated transfers, one per grade (R6)
    issue(2'd0, 18'h00000, 2'd0);
    repeat (30) @(negedge clk);
    issue(2'd3, 18'h3FFFF, 2'd1);
    repeat (30) @(negedge clk);
    issue(2'd1, 18'h12345, 2'd2);
    repeat (30) @(negedge clk);
    issue(2'd2, 18'h2A5A5, 2'd3);
    repeat (30) @(negedge clk);

    // back-to-back: next request waits through access and guard (R8)
    issue(2'd0, 18'h00001, 2'd2);
    issue(2'd1, 18'h3FFFE, 2'd0);
    issue(2'd2, 18'h10000, 2'd1);
    issue(2'd3, 18'h0BEEF, 2'd0);
    issue(2'd0, 18'h3C3C3, 2'd3);
    repeat (40) @(negedge clk);

    // R8: every request answered
    check(received == issued, "R8 response count", received, issued);
    check(expQ.size() == 0, "R8 queue drained", expQ.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule